// File: doc/BRIEF.md
# Dual-Set Blink Waveform Generator

This block produces square-wave blink patterns for a bank of general-purpose pins. Two independent timing sets, A and B, each own a programmable high time and a programmable low time, both counted in core clock cycles. Each set runs its own phase counter and yields one phase signal: high for its on count, low for its off count, then repeating.

Every pin has a select bit that ties it to set A or set B, which gives a per-pin waveform. The pin's final drive comes from a per-pin blink enable. An enabled pin follows its waveform. A disabled pin passes the bank's static output data through unchanged.

Software turns periods into cycle counts and writes them over a small write-only port. A new count written during a phase takes hold only when the current phase ends, so no phase is ever cut short or stretched partway through.

Top module: `dual_blink_gen`

## Requirements
- R1: Reset state. Both sets start in the high phase with their counters at zero. All duration registers hold 0 and all select bits are 0. In the first cycles after reset, every enabled pin drives 1.
- R2: Duration writes. A write with `cfg_we` high loads `cfg_wdata` into the on-duration of the chosen set when `cfg_addr` is 3'h0, and into its off-duration when `cfg_addr` is 3'h4. `cfg_set` = 0 picks set A and 1 picks set B. A write to any other `cfg_addr` value changes nothing.
- R3: Each set's phase is high for exactly its on count and then low for exactly its off count, and this repeats without end.
- R4: A duration register holding 0 gives a phase one cycle long, the same as a value of 1.
- R5: A duration written while a phase is running does not change that phase. It applies from the next phase of that kind that starts after the write.
- R6: A write with `sel_we` high loads the whole `sel_wdata` vector into the select bits. A select bit of 0 makes its pin follow set A and a bit of 1 makes it follow set B.
- R7: `pin_out[i]` equals `blink_wave[i]` when `blink_en[i]` is 1, and equals `out_data[i]` when `blink_en[i]` is 0.
- R8: The two sets are independent. A write to one set never changes the timing of the other set.
- R9: `blink_wave` always shows each pin's selected set phase, whatever the state of `blink_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Duration register write strobe |
| cfg_set | input | 1 | Set chosen for the write: 0 is A, 1 is B |
| cfg_addr | input | 3 | Byte offset: 0x0 selects the on count, 0x4 the off count |
| cfg_wdata | input | 32 | Duration value in clock cycles |
| sel_we | input | 1 | Select vector write strobe |
| sel_wdata | input | NPINS | New per-pin set select bits |
| blink_en | input | NPINS | Per-pin blink enable |
| out_data | input | NPINS | Static output value per pin |
| blink_wave | output | NPINS | Per-pin selected waveform |
| pin_out | output | NPINS | Final per-pin drive |

## Verification
The bench goes after zero durations, which would stall a counter or give a zero-length phase if not forced to one cycle. It also writes a duration mid-phase; a design that loaded the new limit at once would shorten or lengthen the running phase. It checks the split between the two sets and the address decode, where a crossed set or offset bit would retime the wrong waveform, and where decoding a stray offset would overwrite a register. It also applies mixed select and enable patterns, which expose a swapped mux polarity or an enable that leaks the waveform onto a static pin.

// File: rtl/blink_pkg.sv
package blink_pkg;

    localparam int DUR_W = 32;

    localparam logic [2:0] OFF_ON_DUR  = 3'h0;
    localparam logic [2:0] OFF_OFF_DUR = 3'h4;

    typedef struct packed {
        logic             phase;
        logic [DUR_W-1:0] cnt;
        logic [DUR_W-1:0] lim;
    } phase_state_t;

    typedef struct packed {
        logic [1:0][DUR_W-1:0] on_dur;
        logic [1:0][DUR_W-1:0] off_dur;
    } dur_regs_t;

    function automatic logic [DUR_W-1:0] eff_dur(input logic [DUR_W-1:0] raw);
        return (raw == '0) ? {{(DUR_W-1){1'b0}}, 1'b1} : raw;
    endfunction

endpackage

// File: rtl/blink_dur_regs.sv
module blink_dur_regs
    import blink_pkg::*;
#(
    parameter int NSETS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        wr_set,
    input  logic [2:0]                  wr_addr,
    input  logic [DUR_W-1:0]            wr_data,
    output logic [NSETS-1:0][DUR_W-1:0] on_dur,
    output logic [NSETS-1:0][DUR_W-1:0] off_dur
);

    dur_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == OFF_ON_DUR) begin
                regs_d.on_dur[wr_set] = wr_data;
            end else if (wr_addr == OFF_OFF_DUR) begin
                regs_d.off_dur[wr_set] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar s = 0; s < NSETS; s++) begin : g_out
        assign on_dur[s]  = regs_q.on_dur[s];
        assign off_dur[s] = regs_q.off_dur[s];
    end

endmodule

// File: rtl/blink_phase_gen.sv
module blink_phase_gen
    import blink_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DUR_W-1:0] on_dur,
    input  logic [DUR_W-1:0] off_dur,
    output logic             phase,
    output logic [DUR_W-1:0] cnt,
    output logic [DUR_W-1:0] lim
);

    localparam logic [DUR_W-1:0] ONE = {{(DUR_W-1){1'b0}}, 1'b1};

    phase_state_t st_d, st_q;
    logic         last_cyc;

    always_comb begin
        st_d     = st_q;
        last_cyc = (st_q.cnt == st_q.lim - ONE);
        if (last_cyc) begin
            st_d.phase = ~st_q.phase;
            st_d.cnt   = '0;
            st_d.lim   = st_q.phase ? eff_dur(off_dur) : eff_dur(on_dur);
        end else begin
            st_d.cnt   = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= 1'b1;
            st_q.cnt   <= '0;
            st_q.lim   <= ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign cnt   = st_q.cnt;
    assign lim   = st_q.lim;

endmodule

// File: rtl/blink_pin_select.sv
module blink_pin_select #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic [NPINS-1:0] sel_wdata,
    input  logic [1:0]       set_phase,
    input  logic [NPINS-1:0] blink_en,
    input  logic [NPINS-1:0] out_data,
    output logic [NPINS-1:0] blink_wave,
    output logic [NPINS-1:0] pin_out
);

    logic [NPINS-1:0] sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (sel_we) begin
            sel_d = sel_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign blink_wave[p] = sel_q[p] ? set_phase[1] : set_phase[0];
        assign pin_out[p]    = blink_en[p] ? blink_wave[p] : out_data[p];
    end

endmodule

// File: rtl/dual_blink_gen.sv
module dual_blink_gen
    import blink_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_set,
    input  logic [2:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             sel_we,
    input  logic [NPINS-1:0] sel_wdata,
    input  logic [NPINS-1:0] blink_en,
    input  logic [NPINS-1:0] out_data,
    output logic [NPINS-1:0] blink_wave,
    output logic [NPINS-1:0] pin_out
);

    localparam int NSETS = 2;

    logic [NSETS-1:0][DUR_W-1:0] on_dur;
    logic [NSETS-1:0][DUR_W-1:0] off_dur;
    logic [NSETS-1:0]            set_phase;
    logic [NSETS-1:0][DUR_W-1:0] set_cnt;
    logic [NSETS-1:0][DUR_W-1:0] set_lim;

    blink_dur_regs #(.NSETS(NSETS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_set  (cfg_set),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .on_dur  (on_dur),
        .off_dur (off_dur)
    );

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        blink_phase_gen u_phase (
            .clk     (clk),
            .rst_n   (rst_n),
            .on_dur  (on_dur[s]),
            .off_dur (off_dur[s]),
            .phase   (set_phase[s]),
            .cnt     (set_cnt[s]),
            .lim     (set_lim[s])
        );
    end

    blink_pin_select #(.NPINS(NPINS)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_we     (sel_we),
        .sel_wdata  (sel_wdata),
        .set_phase  (set_phase),
        .blink_en   (blink_en),
        .out_data   (out_data),
        .blink_wave (blink_wave),
        .pin_out    (pin_out)
    );

endmodule

// File: rtl/dual_blink_gen_chk.sv
module dual_blink_gen_chk
    import blink_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            phase,
    input logic [1:0][DUR_W-1:0] cnt,
    input logic [1:0][DUR_W-1:0] lim
);

    // R1
    start_high_chk: assert property (@(posedge clk) $rose(rst_n) |-> (phase == 2'b11));

    for (genvar s = 0; s < 2; s++) begin : g_chk
        // R4
        lim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lim[s] != '0);

        // R3
        cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[s] < lim[s]);

        // R3
        phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[s] != lim[s] - 1) |=> $stable(phase[s]));

        // R5
        lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[s] != lim[s] - 1) |=> $stable(lim[s]));

        // R3
        restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[s] == lim[s] - 1) |=> (cnt[s] == '0));
    end

endmodule

bind dual_blink_gen dual_blink_gen_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (set_phase),
    .cnt   (set_cnt),
    .lim   (set_lim)
);

// File: tb/dual_blink_gen_bench.sv
`timescale 1ns/1ps
module dual_blink_gen_bench;

    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_set = 1'b0;
    logic [2:0]    cfg_addr = 3'h0;
    logic [31:0]   cfg_wdata = '0;
    logic          sel_we = 1'b0;
    logic [NP-1:0] sel_wdata = '0;
    logic [NP-1:0] blink_en = '1;
    logic [NP-1:0] out_data = '0;
    logic [NP-1:0] blink_wave;
    logic [NP-1:0] pin_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    dual_blink_gen #(.NPINS(NP)) u_dual_blink_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_set(cfg_set),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .blink_en(blink_en), .out_data(out_data),
        .blink_wave(blink_wave), .pin_out(pin_out)
    );

    // Behavioural reference model
    int unsigned   m_on[2]  = '{0, 0};
    int unsigned   m_off[2] = '{0, 0};
    int unsigned   m_cnt[2] = '{0, 0};
    int unsigned   m_len[2] = '{1, 1};
    bit            m_ph[2]  = '{1, 1};
    logic [NP-1:0] m_sel = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = '{0, 0}; m_off = '{0, 0}; m_cnt = '{0, 0};
            m_len = '{1, 1}; m_ph = '{1, 1}; m_sel = '0;
        end else begin
            for (int s = 0; s < 2; s++) begin
                m_cnt[s]++;
                if (m_cnt[s] >= m_len[s]) begin
                    m_ph[s]  = !m_ph[s];
                    m_cnt[s] = 0;
                    m_len[s] = m_ph[s] ? m_on[s] : m_off[s];
                    if (m_len[s] == 0) m_len[s] = 1;
                end
            end
            if (cfg_we && cfg_addr == 3'h0) m_on[cfg_set] = cfg_wdata;
            if (cfg_we && cfg_addr == 3'h4) m_off[cfg_set] = cfg_wdata;
            if (sel_we) m_sel = sel_wdata;
        end
    end

    task automatic compare();
        logic [NP-1:0] ew, ep;
        for (int i = 0; i < NP; i++) begin
            ew[i] = m_sel[i] ? m_ph[1] : m_ph[0];
            ep[i] = blink_en[i] ? ew[i] : out_data[i];
        end
        checks += 2;
        if (blink_wave !== ew) begin
            errors++;
            $display("FAIL %s blink_wave actual=%h expected=%h", cur_req, blink_wave, ew);
        end
        if (pin_out !== ep) begin
            errors++;
            $display("FAIL %s pin_out actual=%h expected=%h", cur_req, pin_out, ep);
        end
    endtask

    task automatic step(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            compare();
        end
    endtask

    task automatic wr_dur(bit set, logic [2:0] addr, int unsigned val);
        cfg_we = 1'b1; cfg_set = set; cfg_addr = addr; cfg_wdata = val;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic wr_sel(logic [NP-1:0] v);
        sel_we = 1'b1; sel_wdata = v;
        step();
        sel_we = 1'b0;
    endtask

    // Measure the next full high run of pin 0 (select bit 0 must be set as needed)
    task automatic measure_high(int expect_len, string req);
        int len = 0;
        int guard = 0;
        while (blink_wave[0] !== 1'b0 && guard < 1000) begin step(); guard++; end
        while (blink_wave[0] !== 1'b1 && guard < 1000) begin step(); guard++; end
        while (blink_wave[0] === 1'b1 && guard < 1000) begin step(); len++; guard++; end
        checks++;
        if (len != expect_len) begin
            errors++;
            $display("FAIL %s high run actual=%0d expected=%0d", req, len, expect_len);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state with all pins enabled
        cur_req = "R1";
        step(3);
        rst_n = 1'b1;
        step(1);
        // R4: zero durations toggle every cycle
        cur_req = "R4";
        step(8);
        // R2 / R3: program both sets
        cur_req = "R2";
        wr_dur(0, 3'h0, 3);
        wr_dur(0, 3'h4, 5);
        wr_dur(1, 3'h0, 2);
        wr_dur(1, 3'h4, 0);
        cur_req = "R3";
        step(30);
        measure_high(3, "R3");
        // R2: stray offset ignored
        cur_req = "R2";
        wr_dur(0, 3'h2, 9);
        measure_high(3, "R2");
        // R6 / R7 / R9: mixed select, enable and static data
        cur_req = "R6";
        wr_sel(32'hA5A5_0F0E);
        cur_req = "R7";
        blink_en = 32'hFF00_33CC;
        out_data = 32'h1234_5678;
        step(20);
        cur_req = "R9";
        blink_en = '0;
        step(12);
        blink_en = '1;
        // R5: mid-phase duration change
        cur_req = "R5";
        while (!(blink_wave[0] === 1'b1)) step();
        step();
        wr_dur(0, 3'h0, 7);
        step(40);
        measure_high(7, "R5");
        // R8: rewrite set B, set A unaffected
        cur_req = "R8";
        wr_dur(1, 3'h0, 4);
        wr_dur(1, 3'h4, 6);
        measure_high(7, "R8");
        step(30);
        // R4: zero off for set A
        cur_req = "R4";
        wr_dur(0, 3'h4, 0);
        step(30);
        // R1: reset again mid-run
        cur_req = "R1";
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule